// File: doc/BRIEF.md
# Serial Memory Slave Front End with Transfer Pause

This block sits between the pins of a four-wire serial memory slave and its command logic. It oversamples the serial clock, the active-low select and an active-low pause input on the system clock. It assembles received bits into bytes, most significant bit first, and raises a one-clock strobe for each complete byte. It also serializes the bytes that the command logic offers on `txData`. The serial output is driven only while a transfer is running. `sdoEn` is the enable for an external tri-state pad.

The pause input lets the bus master suspend a transfer partway through a byte and continue it later without resending anything. A pause only starts or ends while the serial clock is low. While the transfer is paused, clock and data activity on the pins is ignored and the output pad is released. Three one-hot status outputs report whether the link is idle, active or paused. Decoding instructions, storing data and timing internal writes are left to the surrounding logic.

Top module: `spi_hold_frontend`

## Requirements
- R1: While `csN` is high the block returns to idle: `linkIdle`=1 and `sdoEn`=0. Deselecting the block abandons any partial byte, so the next selection starts counting at bit 7. Exactly one of `linkIdle`, `linkActive` and `linkPaused` is high at any time.
- R2: A sequence starts only on a high-to-low transition of `csN` seen after reset. If `csN` is held low through the release of reset, the block stays idle and ignores clock activity until `csN` has gone high and then low again.
- R3: While the link is active, `sdi` is sampled on each rising `sck` edge, most significant bit first. After every eighth sampled bit, `rxValid` pulses for one system clock with the byte on `rxByte`.
- R4: On selection, `txData` is loaded and its bit 7 appears on `sdo`. Each falling `sck` edge advances `sdo` to the next lower bit. The falling edge that follows the eighth rising edge loads `txData` again.
- R5: If `holdN` is seen low while `sck` is low, the link enters the paused state: `linkPaused`=1 and `sdoEn`=0.
- R6: If `holdN` is seen low while `sck` is high, the link stays active and `sdoEn` stays 1 until the next falling `sck` edge. That falling edge still advances `sdo`, and then the link pauses. The byte then completes intact.
- R7: While paused, `sck` and `sdi` are ignored: no bit is sampled, `rxValid` stays 0 and `sdo` holds its value. The bit position is preserved, so the byte resumes where it stopped.
- R8: A paused link resumes only on a low-to-high transition of `holdN` that occurs while `sck` is low. If `holdN` rises while `sck` is high, the link stays paused, even after `sck` later falls.
- R9: All pin inputs pass through a synchronizer of `SYNC_STAGES` flip-flops, 2 by default. A pin change acts on the outputs within three system clocks, so each `sck` phase must last at least three system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than `sck` |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select from the bus |
| sck | input | 1 | Serial clock from the bus |
| sdi | input | 1 | Serial data from the master |
| holdN | input | 1 | Active-low pause request |
| txData | input | BYTE_BITS | Next byte to serialize |
| rxByte | output | BYTE_BITS | Last received byte |
| rxValid | output | 1 | One-clock strobe when `rxByte` is new |
| sdo | output | 1 | Serial data to the master |
| sdoEn | output | 1 | Output enable for the `sdo` pad |
| linkIdle | output | 1 | Deselected or never selected |
| linkActive | output | 1 | Transfer running |
| linkPaused | output | 1 | Transfer suspended by `holdN` |

## Verification
The hardest state to reach from the ports is a pause requested while `sck` is high. After that, the pause input is raised again while `sck` is still high, and the link must stay paused through the later clock fall. The pause input must move within a clock phase, after the synchronized clock has settled high. The bench therefore stretches each `sck` phase to six system clocks and drives `holdN` two clocks into the high phase. It then walks the link through the rejected release and a proper release. Finally it checks that the interrupted byte arrives unchanged in both directions.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PEND   = 2'd2,   // pause requested with sck high, waits for next fall
    ST_PAUSED = 2'd3
  } linkState_t;

  typedef struct packed {
    logic start;   // new selection: clear bit count, load transmit byte
    logic clear;   // deselect: drop partial byte
    logic sample;  // rising sck: take one input bit
    logic txEdge;  // falling sck: advance or reload output
  } dpStrobe_t;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= RESET_VAL;
        else       pipe[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= RESET_VAL;
        else       pipe[g] <= pipe[g-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sckS,
  input  logic       holdS,
  output dpStrobe_t  strobe,
  output linkState_t state
);

  linkState_t nxt;
  logic csPrev, sckPrev, holdPrev;
  logic csFall, sckRise, sckFall, holdRise;

  // csPrev resets low, matching the synchronizer, so a select held low
  // through reset never looks like a falling edge (R2)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b0;
      sckPrev  <= 1'b0;
      holdPrev <= 1'b1;
      state    <= ST_IDLE;
    end else begin
      csPrev   <= csS;
      sckPrev  <= sckS;
      holdPrev <= holdS;
      state    <= nxt;
    end
  end

  assign csFall   = csPrev & ~csS;
  assign sckRise  = sckS & ~sckPrev;
  assign sckFall  = sckPrev & ~sckS;
  assign holdRise = holdS & ~holdPrev;

  always_comb begin
    nxt    = state;
    strobe = '0;
    if (csS) begin
      nxt          = ST_IDLE;
      strobe.clear = (state != ST_IDLE);
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (csFall) begin
            nxt          = ST_ACTIVE;
            strobe.start = 1'b1;
          end
        end
        ST_ACTIVE: begin
          strobe.sample = sckRise;
          strobe.txEdge = sckFall;
          if (!holdS) nxt = sckS ? ST_PEND : ST_PAUSED;
        end
        ST_PEND: begin
          strobe.txEdge = sckFall;
          if (sckFall) nxt = ST_PAUSED;
        end
        ST_PAUSED: begin
          if (holdRise && !sckS) nxt = ST_ACTIVE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_hold_dp.sv
module spi_hold_dp
  import spi_hold_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic                 sdiS,
  input  logic [BYTE_BITS-1:0] txData,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic                 rxValid,
  output logic                 sdo
);

  localparam int CNT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  logic [CNT_W-1:0]     bitCnt;
  logic [BYTE_BITS-1:0] rxShift, txShift, rxNext;

  assign rxNext = {rxShift[BYTE_BITS-2:0], sdiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strobe.start || strobe.clear) bitCnt <= '0;
      if (strobe.start) txShift <= txData;
      if (strobe.sample) begin
        rxShift <= rxNext;
        if (bitCnt == LAST_BIT) begin
          bitCnt  <= '0;
          rxByte  <= rxNext;
          rxValid <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
      if (strobe.txEdge) begin
        if (bitCnt == '0) txShift <= txData;
        else              txShift <= {txShift[BYTE_BITS-2:0], 1'b0};
      end
    end
  end

  assign sdo = txShift[BYTE_BITS-1];

endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spi_hold_pkg::*;
#(
  parameter int BYTE_BITS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sck,
  input  logic                 sdi,
  input  logic                 holdN,
  input  logic [BYTE_BITS-1:0] txData,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic                 rxValid,
  output logic                 sdo,
  output logic                 sdoEn,
  output logic                 linkIdle,
  output logic                 linkActive,
  output logic                 linkPaused
);

  logic [3:0] syncOut;
  logic       csS, sckS, holdS, sdiS;
  dpStrobe_t  strobe;
  linkState_t state;

  // reset values: select low (no false edge), sck low, hold released, data low
  spi_hold_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'b0010)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({csN, sck, holdN, sdi}),
    .dout(syncOut)
  );

  assign {csS, sckS, holdS, sdiS} = syncOut;

  spi_hold_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .csS   (csS),
    .sckS  (sckS),
    .holdS (holdS),
    .strobe(strobe),
    .state (state)
  );

  spi_hold_dp #(.BYTE_BITS(BYTE_BITS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .sdiS   (sdiS),
    .txData (txData),
    .rxByte (rxByte),
    .rxValid(rxValid),
    .sdo    (sdo)
  );

  assign linkIdle   = (state == ST_IDLE);
  assign linkActive = (state == ST_ACTIVE) || (state == ST_PEND);
  assign linkPaused = (state == ST_PAUSED);
  assign sdoEn      = linkActive;

endmodule

// File: rtl/spi_hold_checker.sv
module spi_hold_checker (
  input logic clk,
  input logic rstN,
  input logic csS,
  input logic sckS,
  input logic rxValid,
  input logic sdo,
  input logic sdoEn,
  input logic linkIdle,
  input logic linkActive,
  input logic linkPaused
);

  p_idle_hiz_r1: assert property (@(posedge clk) disable iff (!rstN)
    linkIdle |-> !sdoEn);

  p_desel_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> linkIdle);

  p_one_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({linkIdle, linkActive, linkPaused}) == 1);

  p_no_start_without_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    linkIdle && !csS && !$past(csS) |=> linkIdle);

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_pause_sck_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkPaused) |-> !$past(sckS));

  p_paused_hiz_r5: assert property (@(posedge clk) disable iff (!rstN)
    linkPaused |-> !sdoEn);

  p_paused_no_rx_r7: assert property (@(posedge clk) disable iff (!rstN)
    linkPaused |-> !rxValid);

  p_paused_sdo_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    linkPaused && $past(linkPaused) |-> $stable(sdo));

  p_resume_sck_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(linkPaused) && linkActive |-> !$past(sckS));

endmodule

bind spi_hold_frontend spi_hold_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csS       (csS),
  .sckS      (sckS),
  .rxValid   (rxValid),
  .sdo       (sdo),
  .sdoEn     (sdoEn),
  .linkIdle  (linkIdle),
  .linkActive(linkActive),
  .linkPaused(linkPaused)
);

// File: tb/sim_spi_hold_frontend.sv
module sim_spi_hold_frontend;

  localparam int H = 6;  // system clocks per sck phase
  // each entry: {byte sent on sdi, byte offered on txData}
  localparam logic [15:0] VEC_TAB [4] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h817E};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, sdi = 1'b0, holdN = 1'b1;
  logic [7:0] txData = 8'h00;
  logic [7:0] rxByte;
  logic rxValid, sdo, sdoEn, linkIdle, linkActive, linkPaused;

  int total = 0;
  int bad = 0;
  int rxCount = 0;
  logic [7:0] lastRx = 8'h00;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_hold_frontend u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi), .holdN(holdN),
    .txData(txData), .rxByte(rxByte), .rxValid(rxValid), .sdo(sdo),
    .sdoEn(sdoEn), .linkIdle(linkIdle), .linkActive(linkActive),
    .linkPaused(linkPaused)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      rxCount <= rxCount + 1;
      lastRx  <= rxByte;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bitXfer(input logic b, output logic o);
    sdi = b;
    tick(H);
    o = sdo;
    sck = 1'b1;
    tick(H);
    sck = 1'b0;
  endtask

  task automatic byteXfer(input logic [7:0] mosi, input logic [7:0] nextTx,
                          output logic [7:0] miso);
    for (int i = 7; i >= 0; i--) begin
      bitXfer(mosi[i], miso[i]);
      if (i == 7) txData = nextTx;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] m;
    int rc;

    // reset state (R1)
    tick(5);
    rstN = 1'b1;
    tick(4);
    check("R1 reset idle", linkIdle, 1);
    check("R1 reset sdoEn", sdoEn, 0);
    check("R3 reset rxValid", rxValid, 0);

    // select held low through reset (R2)
    rstN = 1'b0;
    csN  = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(4);
    check("R2 low at reset stays idle", linkIdle, 1);
    rc = rxCount;
    byteXfer(8'h5A, 8'h00, m);
    tick(4);
    check("R2 no byte before fresh select", rxCount, rc);
    check("R2 still idle", linkIdle, 1);
    csN = 1'b1;
    tick(H);

    // vector table in one selection (R3, R4, R9)
    txData = VEC_TAB[0][7:0];
    csN = 1'b0;
    tick(H);
    check("R2 fresh select active", linkActive, 1);
    for (int v = 0; v < 4; v++) begin
      rc = rxCount;
      byteXfer(VEC_TAB[v][15:8], (v < 3) ? VEC_TAB[v+1][7:0] : 8'h96, m);
      check("R3 rx byte", lastRx, VEC_TAB[v][15:8]);
      check("R3 one strobe per byte", rxCount, rc + 1);
      check("R4 tx byte", m, VEC_TAB[v][7:0]);
    end

    // deselect mid-byte (R1)
    for (int i = 0; i < 3; i++) bitXfer(1'b1, m[0]);
    csN = 1'b1;
    tick(4);
    check("R1 deselect idle", linkIdle, 1);
    check("R1 deselect sdoEn", sdoEn, 0);
    txData = 8'h96;
    csN = 1'b0;
    tick(H);
    byteXfer(8'h3C, 8'hB4, m);
    check("R1 count cleared rx", lastRx, 8'h3C);
    check("R4 tx after reselect", m, 8'h96);

    // pause with sck low (R5, R7, R8)
    for (int i = 7; i >= 5; i--) bitXfer(8'hC6 >> i, m[i]);
    tick(4);
    holdN = 1'b0;
    tick(4);
    check("R5 paused", linkPaused, 1);
    check("R5 paused sdoEn", sdoEn, 0);
    rc = rxCount;
    for (int k = 0; k < 2; k++) begin
      sdi = 1'b0;
      sck = 1'b1;
      tick(H);
      sdi = 1'b1;
      sck = 1'b0;
      tick(H);
    end
    check("R7 still paused", linkPaused, 1);
    check("R7 no strobe while paused", rxCount, rc);
    holdN = 1'b1;
    tick(4);
    check("R8 resume sck low", linkActive, 1);
    for (int i = 4; i >= 0; i--) begin
      bitXfer(8'hC6 >> i, m[i]);
      if (i == 4) txData = 8'h1E;
    end
    check("R7 rx intact", lastRx, 8'hC6);
    check("R7 tx intact", m, 8'hB4);

    // pause requested with sck high (R6, R8)
    for (int i = 7; i >= 5; i--) bitXfer(8'h69 >> i, m[i]);
    sdi = 1'b0;  // bit 4 of 0x69
    tick(H);
    m[4] = sdo;
    sck = 1'b1;
    tick(2);
    holdN = 1'b0;
    tick(4);
    check("R6 active while sck high", linkActive, 1);
    check("R6 sdoEn while sck high", sdoEn, 1);
    sck = 1'b0;
    tick(4);
    check("R6 paused after fall", linkPaused, 1);
    check("R6 fall advanced sdo", sdo, 1);  // bit 3 of 0x1E
    sck = 1'b1;
    tick(4);
    holdN = 1'b1;
    tick(4);
    check("R8 release with sck high ignored", linkPaused, 1);
    sck = 1'b0;
    tick(4);
    check("R8 still paused after fall", linkPaused, 1);
    holdN = 1'b0;
    tick(4);
    holdN = 1'b1;
    tick(4);
    check("R8 proper release", linkActive, 1);
    for (int i = 3; i >= 0; i--) bitXfer(8'h69 >> i, m[i]);
    check("R6 rx intact", lastRx, 8'h69);
    check("R6 tx intact", m, 8'h1E);

    csN = 1'b1;
    tick(4);
    check("R1 final idle", linkIdle, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule